// File: doc/BRIEF.md
# Banked Address Former

This block turns a 16-bit byte offset into a 20-bit physical address for a memory that is divided into 16 banks of 64 KB each. It keeps six 4-bit bank fields. Three of them extend the X, Y and Z index registers. One extends the program counter and one extends the stack pointer. The sixth has no partner register and supplies the bank for operands that use extended addressing.

A requester presents an address source, an offset and an access type on a valid/ready request channel. The block looks up the bank field that belongs to that source and places it above the offset. It also tags the access as program space or data space, based on the access type. The result leaves on a valid/ready response channel, one cycle after the request is accepted.

The bank fields are loaded through plain write strobes. One 16-bit word carries the extended-mode, X, Y and Z fields together. The program-counter field and the stack field each have a port of their own.

Top module: `bank_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, every bank field reads as 0, rsp_valid is 0 and req_ready is 1.
- R2: A write with ext_wr_en loads the extended-mode field from ext_wr_data[15:12], the X field from [11:8], the Y field from [7:4] and the Z field from [3:0].
- R3: pk_wr_en loads the program-counter field from pk_wr_data. sk_wr_en loads the stack field from sk_wr_data. Neither write changes any other field.
- R4: req_src selects the bank field as follows: 0 = X, 1 = Y, 2 = Z, 3 = program counter, 4 = stack, 5 = extended mode. rsp_addr[19:16] carries the selected field and rsp_addr[15:0] carries req_offset.
- R5: rsp_prog is 1 for req_kind 0 (instruction fetch) and req_kind 1 (reset-vector fetch). It is 0 for every other code: 2 = other exception vector, 3 = data, 4 = stack, and 5 to 7, which are treated as data.
- R6: A req_src of 6 or 7 gives bank 0 and rsp_err = 1. A legal source gives rsp_err = 0.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both 1. Its response shows on rsp_valid in the next cycle.
- R8: req_ready equals (!rsp_valid || rsp_ready). While rsp_valid is 1 and rsp_ready is 0, the response holds its value and stays valid.
- R9: A request accepted in the same cycle as a field write uses the field value from before the write. Requests accepted in later cycles see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_wr_en | input | 1 | Write strobe for the packed extended/X/Y/Z word |
| ext_wr_data | input | 16 | Packed field word |
| pk_wr_en | input | 1 | Write strobe for the program-counter bank field |
| pk_wr_data | input | 4 | Program-counter bank value |
| sk_wr_en | input | 1 | Write strobe for the stack bank field |
| sk_wr_data | input | 4 | Stack bank value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_src | input | 3 | Address source code |
| req_offset | input | 16 | Byte offset within the bank |
| req_kind | input | 3 | Access type code |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 20 | Bank and offset combined |
| rsp_prog | output | 1 | 1 = program space, 0 = data space |
| rsp_err | output | 1 | Illegal source code seen |

## Verification
The hardest case to reach is a response that is stalled while field writes and new requests keep arriving. In that case the held address must not follow the changed fields, and the pending request must not be accepted. A second hard case is a write in the same cycle as an accepted request, which must see the old field value. Directed sequences reach both cases with rsp_ready held low and with the writes aligned to the accepting edge. A long run then drives random writes, illegal source codes and random back-pressure. The bench compares every output against a behavioural model on every cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int NUM_FIELDS = 6;

  typedef enum logic [2:0] {
    SRC_X   = 3'd0,
    SRC_Y   = 3'd1,
    SRC_Z   = 3'd2,
    SRC_PC  = 3'd3,
    SRC_SP  = 3'd4,
    SRC_EXT = 3'd5
  } src_e;

  typedef enum logic [2:0] {
    KIND_IFETCH = 3'd0,
    KIND_RSTVEC = 3'd1,
    KIND_EXCVEC = 3'd2,
    KIND_DATA   = 3'd3,
    KIND_STACK  = 3'd4
  } kind_e;
endpackage

// File: rtl/bag_ext_regs.sv
module bag_ext_regs #(
  parameter int BANK_W = 4,
  localparam int NF = bag_pkg::NUM_FIELDS,
  localparam int EXT_W = 4 * BANK_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ext_we,
  input  logic [EXT_W-1:0]          ext_wd,
  input  logic                      pk_we,
  input  logic [BANK_W-1:0]         pk_wd,
  input  logic                      sk_we,
  input  logic [BANK_W-1:0]         sk_wd,
  output logic [NF-1:0][BANK_W-1:0] fields
);
  // Index fields: slot 0 (X) sits highest in the packed word below the extended-mode field
  for (genvar g = 0; g < 3; g++) begin : g_idx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fields[g] <= '0;
      else if (ext_we) fields[g] <= ext_wd[(2-g)*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fields[bag_pkg::SRC_EXT] <= '0;
    else if (ext_we) fields[bag_pkg::SRC_EXT] <= ext_wd[3*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields[bag_pkg::SRC_PC] <= '0;
    else if (pk_we) fields[bag_pkg::SRC_PC] <= pk_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields[bag_pkg::SRC_SP] <= '0;
    else if (sk_we) fields[bag_pkg::SRC_SP] <= sk_wd;
  end
endmodule

// File: rtl/bag_bank_sel.sv
module bag_bank_sel #(
  parameter int BANK_W = 4,
  localparam int NF = bag_pkg::NUM_FIELDS
) (
  input  logic [2:0]                src,
  input  logic [NF-1:0][BANK_W-1:0] fields,
  output logic [BANK_W-1:0]         bank,
  output logic                      bad
);
  always_comb begin
    bank = '0;
    bad  = 1'b1;
    for (int i = 0; i < NF; i++) begin
      if (src == 3'(i)) begin
        bank = fields[i];
        bad  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bag_space_dec.sv
module bag_space_dec (
  input  logic [2:0] kind,
  output logic       prog
);
  always_comb begin
    unique case (kind)
      bag_pkg::KIND_IFETCH,
      bag_pkg::KIND_RSTVEC: prog = 1'b1;
      default:              prog = 1'b0;
    endcase
  end
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 16,
  localparam int ADDR_W = BANK_W + OFF_W,
  localparam int EXT_W  = 4 * BANK_W,
  localparam int NF     = bag_pkg::NUM_FIELDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_wr_en,
  input  logic [EXT_W-1:0]  ext_wr_data,
  input  logic              pk_wr_en,
  input  logic [BANK_W-1:0] pk_wr_data,
  input  logic              sk_wr_en,
  input  logic [BANK_W-1:0] sk_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_src,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [2:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_prog,
  output logic              rsp_err
);
  logic [NF-1:0][BANK_W-1:0] fields;
  logic [BANK_W-1:0]         sel_bank;
  logic                      sel_bad;
  logic                      sel_prog;
  logic                      accept;

  bag_ext_regs #(.BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ext_we(ext_wr_en), .ext_wd(ext_wr_data),
    .pk_we(pk_wr_en), .pk_wd(pk_wr_data),
    .sk_we(sk_wr_en), .sk_wd(sk_wr_data),
    .fields(fields)
  );

  bag_bank_sel #(.BANK_W(BANK_W)) u_sel (
    .src(req_src), .fields(fields), .bank(sel_bank), .bad(sel_bad)
  );

  bag_space_dec u_space (.kind(req_kind), .prog(sel_prog));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_prog  <= 1'b0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= {sel_bank, req_offset};
      rsp_prog  <= sel_prog;
      rsp_err   <= sel_bad;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [2:0]              req_src,
  input logic [OFF_W-1:0]        req_offset,
  input logic [2:0]              req_kind,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [BANK_W+OFF_W-1:0] rsp_addr,
  input logic                    rsp_prog,
  input logic                    rsp_err
);
  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_prog) && $stable(rsp_err));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_addr[OFF_W-1:0] == $past(req_offset));

  // R6
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_src > 3'd5 |=> rsp_err && rsp_addr[BANK_W+OFF_W-1:OFF_W] == '0);

  // R5
  space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_prog == ($past(req_kind) < 3'd2));
endmodule

bind bank_addr_gen bag_chk #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_offset(req_offset), .req_kind(req_kind),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .rsp_prog(rsp_prog), .rsp_err(rsp_err)
);

// File: tb/test_bank_addr_gen.sv
module test_bank_addr_gen;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_wr_en = 1'b0;
  logic [15:0] ext_wr_data = '0;
  logic        pk_wr_en = 1'b0;
  logic [3:0]  pk_wr_data = '0;
  logic        sk_wr_en = 1'b0;
  logic [3:0]  sk_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_src = '0;
  logic [15:0] req_offset = '0;
  logic [2:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [19:0] rsp_addr;
  logic        rsp_prog;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bank_addr_gen i_bank_addr_gen (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  int  fk [6];
  bit  m_valid;
  int  m_bank, m_off;
  bit  m_prog, m_err;

  function automatic int bank_of(int s);
    if (s >= 0 && s < 6) return fk[s];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (fk[i]) fk[i] = 0;
      m_valid = 0; m_bank = 0; m_off = 0; m_prog = 0; m_err = 0;
    end else begin
      if (req_valid && (!m_valid || rsp_ready)) begin
        m_valid = 1;
        m_bank  = bank_of(int'(req_src));
        m_off   = int'(req_offset);
        m_prog  = (req_kind == 0) || (req_kind == 1);
        m_err   = (req_src > 5);
      end else if (rsp_ready) m_valid = 0;
      if (ext_wr_en) begin
        fk[5] = int'(ext_wr_data[15:12]); fk[0] = int'(ext_wr_data[11:8]);
        fk[1] = int'(ext_wr_data[7:4]);   fk[2] = int'(ext_wr_data[3:0]);
      end
      if (pk_wr_en) fk[3] = int'(pk_wr_data);
      if (sk_wr_en) fk[4] = int'(sk_wr_data);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #(PERIOD/4);
    if (!done) begin
      if (!rst_n) begin
        chk("R1 valid in reset", int'(rsp_valid), 0);
      end else begin
        chk("R8 req_ready", int'(req_ready), int'(!m_valid || rsp_ready));
        chk("R7 rsp_valid", int'(rsp_valid), int'(m_valid));
        if (m_valid) begin
          chk("R4 bank", int'(rsp_addr[19:16]), m_bank);
          chk("R4 offset", int'(rsp_addr[15:0]), m_off);
          chk("R5 space", int'(rsp_prog), int'(m_prog));
          chk("R6 err", int'(rsp_err), int'(m_err));
        end
      end
    end
  end

  // single request with rsp_ready high; checks the response one cycle later
  task automatic req1(string tag, int src, int off, int kind, int ebank, int eprog, int eerr);
    @(negedge clk);
    req_valid = 1; req_src = 3'(src); req_offset = 16'(off); req_kind = 3'(kind);
    @(negedge clk);
    req_valid = 0; ext_wr_en = 0; pk_wr_en = 0; sk_wr_en = 0;
    chk({tag, " valid"}, int'(rsp_valid), 1);
    chk({tag, " bank"}, int'(rsp_addr[19:16]), ebank);
    chk({tag, " off"}, int'(rsp_addr[15:0]), off);
    chk({tag, " prog"}, int'(rsp_prog), eprog);
    chk({tag, " err"}, int'(rsp_err), eerr);
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    for (int s = 0; s < 6; s++) req1("R1 cleared field", s, 16'h1000 + s, 3, 0, 0, 0);

    // R2 packed word
    @(negedge clk); ext_wr_en = 1; ext_wr_data = 16'hABCD;
    @(negedge clk); ext_wr_en = 0;
    req1("R2 ext", 5, 16'h0001, 3, 4'hA, 0, 0);
    req1("R2 X", 0, 16'h0002, 3, 4'hB, 0, 0);
    req1("R2 Y", 1, 16'h0003, 4, 4'hC, 0, 0);
    req1("R2 Z", 2, 16'h0004, 2, 4'hD, 0, 0);

    // R3 separate ports
    @(negedge clk); pk_wr_en = 1; pk_wr_data = 4'h7;
    @(negedge clk); pk_wr_en = 0; sk_wr_en = 1; sk_wr_data = 4'h3;
    @(negedge clk); sk_wr_en = 0;
    req1("R3 pc", 3, 16'hFFFF, 0, 7, 1, 0);
    req1("R3 sp", 4, 16'h8000, 4, 3, 0, 0);
    req1("R3 X untouched", 0, 16'h0010, 3, 4'hB, 0, 0);

    // R5 kinds
    req1("R5 rstvec", 3, 16'h0000, 1, 7, 1, 0);
    req1("R5 excvec", 3, 16'h0006, 2, 7, 0, 0);
    req1("R5 kind7", 0, 16'h0020, 7, 4'hB, 0, 0);

    // R6 illegal sources
    req1("R6 src6", 6, 16'h1234, 3, 0, 0, 1);
    req1("R6 src7", 7, 16'h4321, 0, 0, 1, 1);

    // R9 write on accepting edge sees old value
    @(negedge clk);
    ext_wr_en = 1; ext_wr_data = 16'h1555;
    req_valid = 1; req_src = 0; req_offset = 16'h00AA; req_kind = 3;
    @(negedge clk);
    ext_wr_en = 0; req_valid = 0;
    chk("R9 old bank", int'(rsp_addr[19:16]), 4'hB);
    req1("R9 new bank", 0, 16'h00AB, 3, 5, 0, 0);

    // R8 stall: held response, pending request refused
    @(negedge clk);
    req_valid = 1; req_src = 4; req_offset = 16'h0BEE; req_kind = 4; rsp_ready = 0;
    @(negedge clk);
    req_src = 3; req_offset = 16'h0C00; sk_wr_en = 1; sk_wr_data = 4'h9;
    @(negedge clk);
    sk_wr_en = 0;
    chk("R8 ready low", int'(req_ready), 0);
    chk("R8 held addr", int'(rsp_addr), 20'h30BEE);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 next addr", int'(rsp_addr), 20'h70C00);
    @(negedge clk);

    // random traffic with back-pressure
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      ext_wr_en  = ($urandom_range(0, 7) == 0);
      ext_wr_data = 16'($urandom);
      pk_wr_en   = ($urandom_range(0, 7) == 0);
      pk_wr_data = 4'($urandom);
      sk_wr_en   = ($urandom_range(0, 7) == 0);
      sk_wr_data = 4'($urandom);
      req_valid  = ($urandom_range(0, 2) != 0);
      req_src    = 3'($urandom);
      req_offset = 16'($urandom);
      req_kind   = 3'($urandom);
      rsp_ready  = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    req_valid = 0; ext_wr_en = 0; pk_wr_en = 0; sk_wr_en = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    #(PERIOD/2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule